// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Masked Alarm

This block holds the current time of day and calendar date as packed BCD words, plus a day-of-week count. It advances by one second on each cycle where the one-second enable is high. The enable comes from a prescaler outside the block. The hour can run on a 24-hour scale or on a 12-hour scale with an AM/PM flag. Month lengths, including February in leap years, and the two-digit year are handled in BCD directly, with no binary conversion.

Software, or a neighbouring register block, sets the counters through three load strobes: one for time, one for date and one for weekday. An alarm comparator checks every BCD digit of the time and date against alarm words. A per-digit mask takes any digit out of the comparison, so a repeating alarm can be built, such as once a minute or once a day. When a match begins on a tick, a sticky flag is set. A write-1 clear pulse resets the flag. The interrupt output is the flag gated by an enable.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: time is 0x000000, date is 0x000101 (day 01, month 01, year 00), weekday is 0, the alarm flag and the interrupt are 0, and the leap indicator is 1.
- R2: In 24-hour mode (mode input 1), each tick adds one second. The time word packs six BCD digits: seconds units [3:0], seconds tens [6:4], minutes units [11:8], minutes tens [14:12], hours units [19:16] and hours tens [21:20]. After 23:59:59 the time goes to 00:00:00 and the date advances by one day. With no tick and no load, the time holds.
- R3: In 12-hour mode (mode input 0), bit 21 is the PM flag, bit 20 is the hours tens digit and [19:16] is the hours units digit. The hour runs 12, 1, …, 11. The PM flag toggles when the hour goes from 11 to 12. The step from 11:59:59 PM to 12:00:00 AM advances the date.
- R4: The date word holds day units [3:0], day tens [5:4], month units [11:8], month tens [12], year units [19:16] and year tens [23:20]. The last day of each month follows the calendar. February has 29 days when the year is divisible by 4 and 28 days otherwise. Month 12 wraps to 01 and the year steps up. Year 99 wraps to 00.
- R5: The weekday (0 = Sunday … 6 = Saturday) steps by one whenever the date advances, and wraps from 6 to 0.
- R6: The leap indicator is 1 exactly when the current two-digit year is divisible by 4.
- R7: When a load strobe is high, the loaded value appears on the next cycle. A time load in the same cycle as a tick discards that tick.
- R8: Each alarm mask bit excludes one digit from the comparison. In the time mask, bit 0 is seconds units, bit 1 seconds tens, bit 2 minutes units, bit 3 minutes tens, bit 4 hours units and bit 5 hours tens (which includes the PM bit). In the date mask, bit 0 is day units, bit 1 day tens, bit 2 month units, bit 3 month tens, bit 4 year units and bit 5 year tens.
- R9: The alarm flag sets only on a tick whose new time and date match and whose previous time and date did not. A match that stays true over later ticks does not set the flag again.
- R10: The alarm flag stays set until a clear pulse arrives. If a clear pulse and a setting tick fall in the same cycle, the flag ends up set.
- R11: The alarm interrupt is high exactly when the flag is set and the interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1s | input | 1 | One-second advance enable |
| hour24_mode | input | 1 | 1 = 24-hour scale, 0 = 12-hour with PM flag |
| ld_time | input | 1 | Load strobe for the time word |
| time_in | input | 22 | Time value to load |
| ld_date | input | 1 | Load strobe for the date word |
| date_in | input | 24 | Date value to load |
| ld_wday | input | 1 | Load strobe for the weekday |
| wday_in | input | 3 | Weekday value to load |
| alm_time | input | 22 | Alarm time word |
| alm_date | input | 24 | Alarm date word |
| alm_time_mask | input | 6 | Per-digit time exclusion mask |
| alm_date_mask | input | 6 | Per-digit date exclusion mask |
| alm_irq_en | input | 1 | Alarm interrupt enable |
| alm_clear | input | 1 | Write-1 clear pulse for the alarm flag |
| time_now | output | 22 | Current time |
| date_now | output | 24 | Current date |
| wday_now | output | 3 | Current weekday |
| leap_year | output | 1 | Current year is a leap year |
| alm_flag | output | 1 | Sticky alarm flag |
| alm_irq | output | 1 | Gated alarm interrupt |

## Verification
The range assertions take for granted that every loaded time, date and weekday is a legal BCD value for the selected hour scale: no digit above its limit, no day 00, no day past the month's end and no weekday 7. They also assume the hour scale changes only together with a time load. The stimulus keeps to this by building every loaded word from integer hour, minute, second, year, month and day values through encoders in the bench. It switches the mode only just before a time load, and it never drives the reserved weekday code.

// File: rtl/rtc_cal_pkg.sv
// Shared constants and helpers for the BCD calendar.
// Assumes packed BCD words with the field positions given in the brief.
package rtc_cal_pkg;
    localparam int TIME_W = 22;
    localparam int DATE_W = 24;
    localparam int WDAY_W = 3;
    localparam int NDIG   = 6;
    localparam int CMP_W  = 24;

    // Digit fields inside the time word, index = mask bit.
    localparam logic [NDIG-1:0][CMP_W-1:0] TIME_FIELDS = {
        24'h300000, 24'h0F0000, 24'h007000, 24'h000F00, 24'h000070, 24'h00000F};
    // Digit fields inside the date word, index = mask bit.
    localparam logic [NDIG-1:0][CMP_W-1:0] DATE_FIELDS = {
        24'hF00000, 24'h0F0000, 24'h001000, 24'h000F00, 24'h000030, 24'h00000F};

    localparam logic [DATE_W-1:0] DATE_RST = 24'h000101;

    // A BCD year 00..99 is divisible by 4 when an even tens digit meets
    // units 0/4/8, or an odd tens digit meets units 2/6.
    function automatic logic year_is_leap(input logic [7:0] yr);
        if (!yr[4])
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        else
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    // Last day of a BCD month, returned as a 6-bit BCD day.
    function automatic logic [5:0] month_last_day(input logic [4:0] mon,
                                                  input logic leap);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_time_core.sv
// Time-of-day counter in packed BCD, 12- or 24-hour scale.
// Assumes legal loaded values; a load discards a same-cycle tick.
// Raises day_step on the tick that leaves the last second of the day.
module rtc_time_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hour24,
    input  logic              ld,
    input  logic [TIME_W-1:0] ld_val,
    output logic [TIME_W-1:0] cur,
    output logic [TIME_W-1:0] nxt,
    output logic              day_step
);
    logic [TIME_W-1:0] inc;
    logic              wrap;

    // Ripple one second through the BCD digits and the hour scale.
    always_comb begin
        inc  = cur;
        wrap = 1'b0;
        if (cur[3:0] != 4'd9) begin
            inc[3:0] = cur[3:0] + 4'd1;
        end else begin
            inc[3:0] = 4'd0;
            if (cur[6:4] != 3'd5) begin
                inc[6:4] = cur[6:4] + 3'd1;
            end else begin
                inc[6:4] = 3'd0;
                if (cur[11:8] != 4'd9) begin
                    inc[11:8] = cur[11:8] + 4'd1;
                end else begin
                    inc[11:8] = 4'd0;
                    if (cur[14:12] != 3'd5) begin
                        inc[14:12] = cur[14:12] + 3'd1;
                    end else begin
                        inc[14:12] = 3'd0;
                        if (hour24) begin
                            if (cur[21:20] == 2'd2 && cur[19:16] == 4'd3) begin
                                inc[21:16] = 6'd0;
                                wrap       = 1'b1;
                            end else if (cur[19:16] == 4'd9) begin
                                inc[19:16] = 4'd0;
                                inc[21:20] = cur[21:20] + 2'd1;
                            end else begin
                                inc[19:16] = cur[19:16] + 4'd1;
                            end
                        end else begin
                            if (cur[20] && cur[19:16] == 4'd2) begin
                                inc[20]    = 1'b0;
                                inc[19:16] = 4'd1;
                            end else if (cur[20] && cur[19:16] == 4'd1) begin
                                inc[19:16] = 4'd2;
                                inc[21]    = ~cur[21];
                                wrap       = cur[21];
                            end else if (cur[19:16] == 4'd9) begin
                                inc[20]    = 1'b1;
                                inc[19:16] = 4'd0;
                            end else begin
                                inc[19:16] = cur[19:16] + 4'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // Pick the next state: load, then tick, then hold.
    always_comb begin
        nxt      = ld ? ld_val : (tick ? inc : cur);
        day_step = tick & ~ld & wrap;
    end

    // Time register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    // R2
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cur));

    // R2
    time_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[3:0] <= 4'd9) && (cur[6:4] <= 3'd5) && (cur[11:8] <= 4'd9) &&
        (cur[14:12] <= 3'd5) && (cur[19:16] <= 4'd9));
endmodule

// File: rtl/rtc_date_core.sv
// Calendar date in packed BCD plus weekday and leap indicator.
// Assumes legal loaded values; step comes from the time core's day wrap.
module rtc_date_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ld_date,
    input  logic [DATE_W-1:0] date_val,
    input  logic              ld_wday,
    input  logic [WDAY_W-1:0] wday_val,
    output logic [DATE_W-1:0] cur,
    output logic [DATE_W-1:0] nxt,
    output logic [WDAY_W-1:0] wday,
    output logic              leap
);
    logic [DATE_W-1:0] inc;
    logic [5:0]        last_day;

    // Leap status and month length of the current date.
    always_comb begin
        leap     = year_is_leap(cur[23:16]);
        last_day = month_last_day(cur[12:8], leap);
    end

    // Advance day, month and year in BCD.
    always_comb begin
        inc = cur;
        if (cur[5:0] == last_day) begin
            inc[5:0] = 6'h01;
            if (cur[12:8] == 5'h12) begin
                inc[12:8] = 5'h01;
                if (cur[19:16] == 4'd9) begin
                    inc[19:16] = 4'd0;
                    inc[23:20] = (cur[23:20] == 4'd9) ? 4'd0 : cur[23:20] + 4'd1;
                end else begin
                    inc[19:16] = cur[19:16] + 4'd1;
                end
            end else if (cur[11:8] == 4'd9) begin
                inc[12:8] = 5'h10;
            end else begin
                inc[11:8] = cur[11:8] + 4'd1;
            end
        end else if (cur[3:0] == 4'd9) begin
            inc[3:0] = 4'd0;
            inc[5:4] = cur[5:4] + 2'd1;
        end else begin
            inc[3:0] = cur[3:0] + 4'd1;
        end
    end

    // Next date: load wins over a day step.
    always_comb begin
        nxt = ld_date ? date_val : (step ? inc : cur);
    end

    // Date and weekday registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= DATE_RST;
            wday <= '0;
        end else begin
            cur <= nxt;
            if (ld_wday)   wday <= wday_val;
            else if (step) wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
        end
    end

    // R5
    wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wday != 3'd7);

    // R4
    date_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[5:0] != 6'd0) && (cur[3:0] <= 4'd9) && (cur[12:8] != 5'd0) &&
        (cur[12:8] <= 5'h12) && (cur[19:16] <= 4'd9) && (cur[23:20] <= 4'd9));
endmodule

// File: rtl/rtc_digit_match.sv
// Per-digit equality with a mask bit per digit.
// Assumes FIELDS lists disjoint bit groups, one per mask bit.
module rtc_digit_match #(
    parameter int N = 6,
    parameter int W = 24,
    parameter logic [N-1:0][W-1:0] FIELDS = '0
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] ref_val,
    input  logic [N-1:0] mask,
    output logic         hit
);
    logic [N-1:0] dig_ok;

    // One equality test per digit field.
    for (genvar i = 0; i < N; i++) begin : g_dig
        assign dig_ok[i] = mask[i] | (((val ^ ref_val) & FIELDS[i]) == '0);
    end

    assign hit = &dig_ok;
endmodule

// File: rtl/rtc_bcd_calendar.sv
// Top: time core, date core, masked alarm comparators and sticky flag.
// Assumes tick_1s is a one-cycle enable from an external prescaler.
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              hour24_mode,
    input  logic              ld_time,
    input  logic [TIME_W-1:0] time_in,
    input  logic              ld_date,
    input  logic [DATE_W-1:0] date_in,
    input  logic              ld_wday,
    input  logic [WDAY_W-1:0] wday_in,
    input  logic [TIME_W-1:0] alm_time,
    input  logic [DATE_W-1:0] alm_date,
    input  logic [NDIG-1:0]   alm_time_mask,
    input  logic [NDIG-1:0]   alm_date_mask,
    input  logic              alm_irq_en,
    input  logic              alm_clear,
    output logic [TIME_W-1:0] time_now,
    output logic [DATE_W-1:0] date_now,
    output logic [WDAY_W-1:0] wday_now,
    output logic              leap_year,
    output logic              alm_flag,
    output logic              alm_irq
);
    localparam int PAD = CMP_W - TIME_W;

    logic [TIME_W-1:0] time_nxt;
    logic [DATE_W-1:0] date_nxt;
    logic              day_step;
    logic [1:0]        t_hit, d_hit;
    logic              tick_eff, set_ev;

    rtc_time_core u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick_1s), .hour24(hour24_mode),
        .ld(ld_time), .ld_val(time_in), .cur(time_now), .nxt(time_nxt),
        .day_step(day_step));

    rtc_date_core u_date (
        .clk(clk), .rst_n(rst_n), .step(day_step), .ld_date(ld_date),
        .date_val(date_in), .ld_wday(ld_wday), .wday_val(wday_in),
        .cur(date_now), .nxt(date_nxt), .wday(wday_now), .leap(leap_year));

    // Comparators: index 0 sees the present value, index 1 the next one.
    for (genvar g = 0; g < 2; g++) begin : g_cmp
        rtc_digit_match #(.N(NDIG), .W(CMP_W), .FIELDS(TIME_FIELDS)) u_tm (
            .val({{PAD{1'b0}}, (g == 0) ? time_now : time_nxt}),
            .ref_val({{PAD{1'b0}}, alm_time}), .mask(alm_time_mask),
            .hit(t_hit[g]));
        rtc_digit_match #(.N(NDIG), .W(CMP_W), .FIELDS(DATE_FIELDS)) u_dm (
            .val((g == 0) ? date_now : date_nxt), .ref_val(alm_date),
            .mask(alm_date_mask), .hit(d_hit[g]));
    end

    // A match begins on an applied tick.
    always_comb begin
        tick_eff = tick_1s & ~ld_time;
        set_ev   = tick_eff & t_hit[1] & d_hit[1] & ~(t_hit[0] & d_hit[0]);
    end

    // Sticky flag; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         alm_flag <= 1'b0;
        else if (set_ev)    alm_flag <= 1'b1;
        else if (alm_clear) alm_flag <= 1'b0;
    end

    assign alm_irq = alm_flag & alm_irq_en;

    // R9
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> $past(tick_1s && !ld_time));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alm_clear) && !$past(tick_1s)) |-> !alm_flag);
endmodule

// File: tb/tb_rtc_bcd_calendar.sv
module tb_rtc_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1s = 1'b0;
    logic        hour24_mode = 1'b1;
    logic        ld_time = 1'b0, ld_date = 1'b0, ld_wday = 1'b0;
    logic [21:0] time_in = '0;
    logic [23:0] date_in = '0;
    logic [2:0]  wday_in = '0;
    logic [21:0] alm_time = '0;
    logic [23:0] alm_date = '0;
    logic [5:0]  alm_time_mask = '0, alm_date_mask = '0;
    logic        alm_irq_en = 1'b0, alm_clear = 1'b0;
    logic [21:0] time_now;
    logic [23:0] date_now;
    logic [2:0]  wday_now;
    logic        leap_year, alm_flag, alm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_bcd_calendar dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] tenc(input int s, input bit h24);
        int h = (s / 3600) % 24;
        int m = (s / 60) % 60;
        int x = s % 60;
        int h12 = (h % 12 == 0) ? 12 : h % 12;
        if (h24)
            return {2'(h / 10), 4'(h % 10), 1'b0, 3'(m / 10), 4'(m % 10), 1'b0, 3'(x / 10), 4'(x % 10)};
        return {(h >= 12), 1'(h12 / 10), 4'(h12 % 10), 1'b0, 3'(m / 10), 4'(m % 10), 1'b0, 3'(x / 10), 4'(x % 10)};
    endfunction

    function automatic logic [23:0] denc(input int y, input int m, input int d);
        return {4'(y / 10), 4'(y % 10), 3'b0, 1'(m / 10), 4'(m % 10), 2'b0, 2'(d / 10), 4'(d % 10)};
    endfunction

    function automatic int dim(input int y, input int m);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic load(input bit lt, input logic [21:0] t, input bit ld, input logic [23:0] d,
                        input bit lw, input logic [2:0] w);
        ld_time = lt; time_in = t; ld_date = ld; date_in = d; ld_wday = lw; wday_in = w;
        @(negedge clk);
        ld_time = 1'b0; ld_date = 1'b0; ld_wday = 1'b0;
    endtask

    task automatic tick1();
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic clear_flag();
        alm_clear = 1'b1;
        @(negedge clk);
        alm_clear = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int y, m, d, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 time", 32'(time_now), 32'h0);
        chk("R1 date", 32'(date_now), 32'h000101);
        chk("R1 wday", 32'(wday_now), 32'h0);
        chk("R1 flag", 32'(alm_flag), 32'h0);
        chk("R1 irq", 32'(alm_irq), 32'h0);
        chk("R1 leap", 32'(leap_year), 32'h1);

        // R2 hold with no tick
        repeat (3) @(negedge clk);
        chk("R2 hold", 32'(time_now), 32'h0);

        // R2 full-day sweep, 24-hour scale
        tick_1s = 1'b1;
        for (int k = 0; k < 86400; k++) begin
            @(negedge clk);
            chk("R2 sweep", 32'(time_now), 32'(tenc((k + 1) % 86400, 1'b1)));
        end
        tick_1s = 1'b0;
        chk("R2 day carry", 32'(date_now), 32'h000102);
        chk("R5 wday step", 32'(wday_now), 32'h1);

        // R3 every hour boundary on the 12-hour scale
        hour24_mode = 1'b0;
        for (int h = 0; h < 24; h++) begin
            load(1'b1, tenc(h * 3600 + 3599, 1'b0), 1'b1, 24'h000101, 1'b1, 3'd0);
            tick1();
            chk("R3 hour step", 32'(time_now), 32'(tenc(((h + 1) * 3600) % 86400, 1'b0)));
            chk("R3 date", 32'(date_now), (h == 23) ? 32'h000102 : 32'h000101);
        end

        // R4 R5 R6 day-by-day sweep over four years
        hour24_mode = 1'b1;
        y = 0; m = 1; d = 1; w = 6;
        load(1'b0, '0, 1'b1, denc(0, 1, 1), 1'b1, 3'd6);
        for (int n = 0; n < 1461; n++) begin
            load(1'b1, tenc(86399, 1'b1), 1'b0, '0, 1'b0, '0);
            tick1();
            if (d == dim(y, m)) begin
                d = 1;
                if (m == 12) begin m = 1; y = (y + 1) % 100; end
                else m++;
            end else d++;
            w = (w == 6) ? 0 : w + 1;
            chk("R4 date", 32'(date_now), 32'(denc(y, m, d)));
            chk("R5 wday", 32'(wday_now), 32'(w));
            chk("R6 leap", 32'(leap_year), 32'(y % 4 == 0));
        end
        // R4 year wrap
        load(1'b1, tenc(86399, 1'b1), 1'b1, denc(99, 12, 31), 1'b1, 3'd6);
        tick1();
        chk("R4 year wrap", 32'(date_now), 32'(denc(0, 1, 1)));
        chk("R5 wday wrap", 32'(wday_now), 32'h0);
        // R6 all years
        for (int yy = 0; yy < 100; yy++) begin
            load(1'b0, '0, 1'b1, denc(yy, 3, 1), 1'b0, '0);
            chk("R6 leap year", 32'(leap_year), 32'(yy % 4 == 0));
        end

        // R7 load discards a same-cycle tick
        tick_1s = 1'b1;
        load(1'b1, tenc(3725, 1'b1), 1'b0, '0, 1'b0, '0);
        tick_1s = 1'b0;
        chk("R7 load wins", 32'(time_now), 32'(tenc(3725, 1'b1)));

        // R9 R11 exact alarm, sticky, interrupt gating
        load(1'b1, '0, 1'b1, 24'h000101, 1'b0, '0);
        alm_time = tenc(5, 1'b1); alm_date = 24'h000101;
        alm_time_mask = '0; alm_date_mask = '0;
        clear_flag();
        for (int k = 1; k <= 8; k++) begin
            tick1();
            chk("R9 exact", 32'(alm_flag), 32'(k >= 5));
            chk("R11 irq off", 32'(alm_irq), 32'h0);
        end
        alm_irq_en = 1'b1;
        #1 chk("R11 irq on", 32'(alm_irq), 32'h1);
        @(negedge clk);
        clear_flag();
        chk("R10 clear", 32'(alm_flag), 32'h0);
        chk("R11 irq cleared", 32'(alm_irq), 32'h0);
        alm_irq_en = 1'b0;

        // R8 only seconds units compared
        load(1'b1, '0, 1'b0, '0, 1'b0, '0);
        alm_time = 22'h000003; alm_time_mask = 6'b111110; alm_date_mask = 6'h3F;
        for (int k = 1; k <= 30; k++) begin
            tick1();
            chk("R8 sec units", 32'(alm_flag), 32'((k % 10) == 3));
            clear_flag();
        end

        // R9 held match sets once: only minutes units compared
        load(1'b1, tenc(55, 1'b1), 1'b0, '0, 1'b0, '0);
        alm_time = tenc(60, 1'b1); alm_time_mask = 6'b111011;
        for (int k = 1; k <= 70; k++) begin
            tick1();
            chk("R9 once", 32'(alm_flag), 32'(k == 5));
            clear_flag();
        end

        // R8 unmasked date digit blocks, masking it allows
        load(1'b1, '0, 1'b1, 24'h000101, 1'b0, '0);
        alm_time = tenc(2, 1'b1); alm_time_mask = '0;
        alm_date = 24'h000102; alm_date_mask = '0;
        repeat (4) tick1();
        chk("R8 date blocks", 32'(alm_flag), 32'h0);
        load(1'b1, '0, 1'b0, '0, 1'b0, '0);
        alm_date_mask = 6'b000001;
        tick1();
        chk("R8 day masked", 32'(alm_flag), 32'h0);
        tick1();
        chk("R8 day masked", 32'(alm_flag), 32'h1);

        // R10 set wins over a same-cycle clear
        load(1'b1, '0, 1'b0, '0, 1'b0, '0);
        alm_time = tenc(1, 1'b1); alm_date = 24'h000101; alm_date_mask = '0;
        clear_flag();
        alm_clear = 1'b1;
        tick1();
        alm_clear = 1'b0;
        chk("R10 set wins", 32'(alm_flag), 32'h1);

        // R3 R8 noon alarm with PM bit on 12-hour scale
        hour24_mode = 1'b0;
        alm_time = tenc(12 * 3600, 1'b0);
        load(1'b1, tenc(12 * 3600 - 1, 1'b0), 1'b0, '0, 1'b0, '0);
        clear_flag();
        tick1();
        chk("R3 noon time", 32'(time_now), 32'(tenc(12 * 3600, 1'b0)));
        chk("R8 noon alarm", 32'(alm_flag), 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule